// File: doc/BRIEF.md
# Read Port with Emulated Enable and Reset

This block wraps a small synchronous RAM whose raw read port has neither a clock enable nor a reset. The raw port reads every clock edge. Soft logic around it rebuilds a full read port with a read enable, a power-up output value, an active-high asynchronous reset and an active-high synchronous reset. A one-bit select register remembers whether the last edge performed an enabled read. A hold register keeps the last output word. An output multiplexer picks the fresh RAM word or the held word. Both resets clear the select register and load the hold register with their own reset value.

A parameter sets the priority between the read enable and the synchronous reset. In enable-priority mode the synchronous reset only acts in cycles where the read enable is also high. The block gets this by gating the reset with the enable before it reaches the emulation registers. In reset-priority mode the synchronous reset acts on its own. The single write port goes straight to the RAM. A read and a write to the same address in the same edge return the old word.

Top module: `rd_port_emu`

## Requirements
- R1: From power-up, before any reset and before any enabled read, `rd_data` equals INIT_VAL.
- R2: When `rd_en` is 1 at a rising edge and no synchronous reset takes effect, `rd_data` after that edge is the word stored at `rd_addr` before the edge. A write to the same address in the same edge is not seen.
- R3: When `rd_en` is 0 at a rising edge and no synchronous reset takes effect, `rd_data` keeps its value, even if the RAM word it came from is overwritten.
- R4: While `arst` is 1, `rd_data` equals ARST_VAL with no clock edge needed. After release it keeps ARST_VAL until an enabled read or a synchronous reset takes effect.
- R5: With PRIO = PRIO_CE, a rising edge with `srst` = 1 and `rd_en` = 1 makes `rd_data` equal SRST_VAL. A rising edge with `srst` = 1 and `rd_en` = 0 leaves `rd_data` unchanged.
- R6: With PRIO = PRIO_SRST, a rising edge with `srst` = 1 makes `rd_data` equal SRST_VAL whatever `rd_en` is.
- R7: When `wr_en` is 1 at a rising edge, `wr_data` is stored at `wr_addr`. An enabled read of that address at a later edge returns it.
- R8: `arst` overrides `srst` and `rd_en`. An edge seen while `arst` is 1 leaves `rd_data` at ARST_VAL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for the RAM and the emulation registers |
| arst | input | 1 | Asynchronous reset of the read output, active high |
| srst | input | 1 | Synchronous reset of the read output, active high |
| rd_en | input | 1 | Read enable |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Read data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |

## Verification
Two instances run side by side from the same stimulus, one in each priority mode. They are compared every cycle against a behavioural port model.

The stimulus patterns and what each one separates:
- A preload phase with reads disabled separates the power-up value from stale RAM output.
- Directed vectors that overwrite a held address separate a true hold from a re-read.
- Vectors with the synchronous reset applied without enable separate the two priority modes.
- Same-address read and write edges pin down read-first ordering.
- A pseudo-random phase mixes enable, reset and write patterns.
- A mid-cycle asynchronous reset shows the output changing without a clock edge and overriding the other controls.

// File: rtl/rdemu_pkg.sv
package rdemu_pkg;
   // Which control wins when read enable and synchronous reset disagree
   typedef enum logic {
      PRIO_CE   = 1'b0,   // synchronous reset acts only together with rd_en
      PRIO_SRST = 1'b1    // synchronous reset acts on its own
   } prio_e;
endpackage

// File: rtl/rdemu_ram.sv
module rdemu_ram #(
   parameter int DW = 8,
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   // raw read port: no enable, no reset, reads old data on collision
   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/rdemu_prio.sv
module rdemu_prio #(
   parameter rdemu_pkg::prio_e PRIO = rdemu_pkg::PRIO_CE
) (
   input  logic srst,
   input  logic rd_en,
   output logic srst_eff
);
   generate
      if (PRIO == rdemu_pkg::PRIO_CE) begin : g_gate
         // enable-priority port recast as reset-priority: reset needs enable
         assign srst_eff = srst & rd_en;
      end else begin : g_pass
         assign srst_eff = srst;
      end
   endgenerate
endmodule

// File: rtl/rdemu_hold.sv
module rdemu_hold #(
   parameter int          DW       = 8,
   parameter logic [DW-1:0] INIT_VAL = '0,
   parameter logic [DW-1:0] ARST_VAL = '0,
   parameter logic [DW-1:0] SRST_VAL = '0
) (
   input  logic          clk,
   input  logic          arst,
   input  logic          srst_eff,
   input  logic          rd_en,
   input  logic [DW-1:0] ram_q,
   output logic [DW-1:0] dout
);
   // power-up: fresh data not selected, held word is the initial value
   logic          sel_q  = 1'b0;
   logic [DW-1:0] hold_q = INIT_VAL;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         sel_q  <= 1'b0;
         hold_q <= ARST_VAL;
      end else if (srst_eff) begin
         sel_q  <= 1'b0;
         hold_q <= SRST_VAL;
      end else begin
         sel_q  <= rd_en;
         hold_q <= dout;
      end
   end

   assign dout = sel_q ? ram_q : hold_q;
endmodule

// File: rtl/rd_port_emu.sv
module rd_port_emu #(
   parameter int              DW       = 8,
   parameter int              AW       = 4,
   parameter logic [DW-1:0]   INIT_VAL = 8'hA5,
   parameter logic [DW-1:0]   ARST_VAL = 8'h3C,
   parameter logic [DW-1:0]   SRST_VAL = 8'h5A,
   parameter rdemu_pkg::prio_e PRIO    = rdemu_pkg::PRIO_CE
) (
   input  logic          clk,
   input  logic          arst,
   input  logic          srst,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data
);
   generate
      if (DW < 1) begin : g_bad_dw
         $error("rd_port_emu: DW must be at least 1");
      end
      if (AW < 1 || AW > 12) begin : g_bad_aw
         $error("rd_port_emu: AW must lie in 1..12");
      end
   endgenerate

   logic [DW-1:0] ram_q;
   logic          srst_eff;

   rdemu_ram #(.DW(DW), .AW(AW)) u_ram (
      .clk   (clk),
      .we    (wr_en),
      .waddr (wr_addr),
      .wdata (wr_data),
      .raddr (rd_addr),
      .rdata (ram_q)
   );

   rdemu_prio #(.PRIO(PRIO)) u_prio (
      .srst     (srst),
      .rd_en    (rd_en),
      .srst_eff (srst_eff)
   );

   rdemu_hold #(
      .DW(DW), .INIT_VAL(INIT_VAL), .ARST_VAL(ARST_VAL), .SRST_VAL(SRST_VAL)
   ) u_hold (
      .clk      (clk),
      .arst     (arst),
      .srst_eff (srst_eff),
      .rd_en    (rd_en),
      .ram_q    (ram_q),
      .dout     (rd_data)
   );
endmodule

// File: rtl/rd_port_emu_chk.sv
module rd_port_emu_chk #(
   parameter int              DW       = 8,
   parameter logic [DW-1:0]   ARST_VAL = '0,
   parameter logic [DW-1:0]   SRST_VAL = '0,
   parameter rdemu_pkg::prio_e PRIO    = rdemu_pkg::PRIO_CE
) (
   input logic          clk,
   input logic          arst,
   input logic          srst,
   input logic          rd_en,
   input logic [DW-1:0] rd_data,
   input logic [DW-1:0] ram_q
);
   // R4 R8
   arst_value_chk: assert property (@(posedge clk) arst |-> rd_data == ARST_VAL);

   // R2
   fresh_read_chk: assert property (@(posedge clk) disable iff (arst)
      (rd_en && !srst) |=> rd_data == ram_q);

   generate
      if (PRIO == rdemu_pkg::PRIO_CE) begin : g_ce
         // R5
         srst_with_en_chk: assert property (@(posedge clk) disable iff (arst)
            (srst && rd_en) |=> rd_data == SRST_VAL);
         // R3 R5
         hold_ce_chk: assert property (@(posedge clk) disable iff (arst)
            !rd_en |=> $stable(rd_data));
      end else begin : g_srst
         // R6
         srst_alone_chk: assert property (@(posedge clk) disable iff (arst)
            srst |=> rd_data == SRST_VAL);
         // R3
         hold_srst_chk: assert property (@(posedge clk) disable iff (arst)
            (!rd_en && !srst) |=> $stable(rd_data));
      end
   endgenerate
endmodule

bind rd_port_emu rd_port_emu_chk #(
   .DW(DW), .ARST_VAL(ARST_VAL), .SRST_VAL(SRST_VAL), .PRIO(PRIO)
) u_chk (
   .clk     (clk),
   .arst    (arst),
   .srst    (srst),
   .rd_en   (rd_en),
   .rd_data (rd_data),
   .ram_q   (ram_q)
);

// File: tb/rd_port_emu_tb.sv
module rd_port_emu_tb;
   localparam int DW = 8;
   localparam int AW = 4;
   localparam logic [DW-1:0] INIT_V = 8'hA5;
   localparam logic [DW-1:0] ARST_V = 8'h3C;
   localparam logic [DW-1:0] SRST_V = 8'h5A;

   typedef struct packed {
      logic          wen;
      logic [AW-1:0] waddr;
      logic [DW-1:0] wdata;
      logic          ren;
      logic [AW-1:0] raddr;
      logic          srst;
   } vec_t;

   // stimulus; expected values come from the port model below
   localparam vec_t VEC [12] = '{
      '{1'b0, 4'h0, 8'h00, 1'b1, 4'h2, 1'b0},  // R2 read
      '{1'b0, 4'h0, 8'h00, 1'b0, 4'h7, 1'b0},  // R3 hold
      '{1'b1, 4'h2, 8'h77, 1'b0, 4'h2, 1'b0},  // R3 hold while word changes
      '{1'b0, 4'h0, 8'h00, 1'b1, 4'h2, 1'b0},  // R7 new word
      '{1'b0, 4'h0, 8'h00, 1'b0, 4'h5, 1'b1},  // R5 ignored / R6 reset
      '{1'b0, 4'h0, 8'h00, 1'b1, 4'h5, 1'b1},  // R5 R6 reset
      '{1'b0, 4'h0, 8'h00, 1'b1, 4'h5, 1'b0},  // R2
      '{1'b1, 4'h5, 8'h99, 1'b1, 4'h5, 1'b0},  // R2 read-first
      '{1'b0, 4'h0, 8'h00, 1'b1, 4'h5, 1'b0},  // R7
      '{1'b0, 4'h0, 8'h00, 1'b0, 4'h1, 1'b1},  // R5 R6
      '{1'b0, 4'h0, 8'h00, 1'b0, 4'h1, 1'b0},  // R3
      '{1'b0, 4'h0, 8'h00, 1'b1, 4'hF, 1'b0}   // R2
   };

   logic          clk = 1'b0;
   logic          arst = 1'b0, srst = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
   logic [AW-1:0] rd_addr = '0, wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] dout_c, dout_s;

   int checks = 0, errors = 0;
   logic [DW-1:0] mdl_mem [1 << AW];
   logic [DW-1:0] exp_c = INIT_V, exp_s = INIT_V;
   logic [31:0]   lfsr = 32'h1ACE_B00C;

   always #4 clk = ~clk;

   rd_port_emu #(.DW(DW), .AW(AW), .INIT_VAL(INIT_V), .ARST_VAL(ARST_V),
                 .SRST_VAL(SRST_V), .PRIO(rdemu_pkg::PRIO_CE)) u_dut (
      .clk(clk), .arst(arst), .srst(srst), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(dout_c), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

   rd_port_emu #(.DW(DW), .AW(AW), .INIT_VAL(INIT_V), .ARST_VAL(ARST_V),
                 .SRST_VAL(SRST_V), .PRIO(rdemu_pkg::PRIO_SRST)) u_dut_sp (
      .clk(clk), .arst(arst), .srst(srst), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(dout_s), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // one clock with the current inputs; inputs change only after posedge+1
   task automatic tick(input string force_tag);
      string tc, ts;
      logic [DW-1:0] word = mdl_mem[rd_addr];
      if (rd_en) exp_c = srst ? SRST_V : word;
      tc = (srst) ? "R5" : (rd_en ? "R2" : "R3");
      if (srst)       exp_s = SRST_V;
      else if (rd_en) exp_s = word;
      ts = (srst) ? "R6" : (rd_en ? "R2" : "R3");
      if (force_tag != "") begin tc = force_tag; ts = force_tag; end
      @(posedge clk);
      if (wr_en) mdl_mem[wr_addr] = wr_data;
      #1;
      check({tc, " prio-ce"}, dout_c, exp_c);
      check({ts, " prio-srst"}, dout_s, exp_s);
   endtask

   task automatic drive(input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                        input logic re, input logic [AW-1:0] ra, input logic sr);
      wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra; srst = sr;
   endtask

   logic done = 1'b0;

   initial begin
      #2;
      // R1 power-up value, no edge yet
      check("R1 powerup prio-ce", dout_c, INIT_V);
      check("R1 powerup prio-srst", dout_s, INIT_V);

      // preload every word with reads off: output stays at the initial value (R1)
      for (int i = 0; i < (1 << AW); i++) begin
         drive(1'b1, AW'(i), {4'(i), ~4'(i)}, 1'b0, '0, 1'b0);
         tick("R1");
      end

      for (int i = 0; i < 12; i++) begin
         drive(VEC[i].wen, VEC[i].waddr, VEC[i].wdata, VEC[i].ren, VEC[i].raddr, VEC[i].srst);
         tick("");
      end

      // R7 directed: write then read back
      drive(1'b1, 4'h3, 8'hC7, 1'b0, 4'h3, 1'b0); tick("");
      drive(1'b0, 4'h0, 8'h00, 1'b1, 4'h3, 1'b0); tick("R7");
      check("R7 readback prio-ce", dout_c, 8'hC7);

      // pseudo-random mix
      for (int i = 0; i < 400; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         drive(lfsr[0], lfsr[7:4], lfsr[15:8], lfsr[1] | lfsr[2], lfsr[19:16],
               lfsr[3] & lfsr[20]);
         tick("");
      end

      // R4 R8: asynchronous reset mid-cycle with every other control active
      drive(1'b0, 4'h0, 8'h00, 1'b1, 4'h6, 1'b1);
      #2 arst = 1'b1;
      #1;
      check("R4 async prio-ce", dout_c, ARST_V);
      check("R4 async prio-srst", dout_s, ARST_V);
      @(posedge clk); #1;
      check("R8 edge under reset prio-ce", dout_c, ARST_V);
      check("R8 edge under reset prio-srst", dout_s, ARST_V);
      drive(1'b0, 4'h0, 8'h00, 1'b0, 4'h6, 1'b0);
      #2 arst = 1'b0;
      exp_c = ARST_V; exp_s = ARST_V;
      tick("R4");
      drive(1'b0, 4'h0, 8'h00, 1'b1, 4'h6, 1'b0);
      tick("");
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule